// File: doc/BRIEF.md
# Decoded Micro-op Trace Cache

This block keeps micro-operations that a decoder has already produced, so a later fetch of the same path can skip decoding. Each stored line is a trace: a run of micro-ops in the order the program executes them. A trace can run on past a branch in the direction the predictor chose, so one line may hold operations from addresses that are not contiguous. Its tag is the trace's start address, the owning hardware thread, and the predicted directions of the branches inside it.

A builder packs decoder output, one micro-op per clock, into a line and writes the line into a set-associative array when the line closes. A line closes when it is full, when it holds its last allowed branch, or when the decoder marks the end of a trace. Two hardware threads share the array. Each cycle, one thread gets the fetch slot, and the slot alternates between the threads. A fetch that hits streams the line to a consumer, a bounded number of micro-ops per beat, under a valid/ready handshake. A fetch that misses is reported at once, so the decoder path can be used instead.

Top module: `tc_trace_cache`

## Requirements
- R1: After reset every line is invalid: `out_valid_o` is low and the first lookup of any address misses.
- R2: Micro-ops of a trace are stored in arrival order. A line closes automatically after its 6th micro-op. The next micro-op starts a new trace whose start address is that micro-op's `fill_pc_i`.
- R3: A line also closes on the micro-op that carries its 2nd branch (`fill_br_i`=1), or on any micro-op with `fill_last_i`=1, whichever comes first.
- R4: A lookup hits only if the start address and thread ID match, and the prediction matches the line's embedded branches. Bit i of a thread's `req_pred_i` field (1 = taken) must equal the direction of the line's i-th branch, for each branch the line holds.
- R5: A hit is acknowledged on `req_ack_o` in its lookup cycle. Beats start on the next cycle. Each beat carries min(3, remaining) micro-ops in stored order: slot k in bits [16k+15:16k] of `out_uops_o`, with `out_cnt_o` giving the count.
- R6: While `out_valid_o` is high and `out_ready_i` is low, the beat (tid, count, micro-ops) stays unchanged on the next cycle.
- R7: A miss raises `miss_o`, with the thread on `miss_tid_o`, in the cycle the request is acknowledged. No beat follows.
- R8: When both threads want the slot, grants alternate each cycle. When only one thread wants it, that thread gets every cycle.
- R9: `flush_i` invalidates every line in one cycle and ends any stream in progress.
- R10: A new line goes to an invalid way of its set if there is one, and otherwise to the tree pseudo-LRU victim. Lookup hits and writes both update the LRU state. A rewrite of an existing tag reuses that tag's way.
- R11: Lines of one thread never hit for the other thread at the same start address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| flush_i | input | 1 | Invalidate all lines |
| fill_valid_i | input | 1 | Decoder micro-op present |
| fill_tid_i | input | 1 | Thread of the trace (taken from its first micro-op) |
| fill_pc_i | input | 16 | Address of the micro-op's instruction |
| fill_uop_i | input | 16 | Decoded micro-op |
| fill_br_i | input | 1 | Micro-op is a predicted branch |
| fill_taken_i | input | 1 | Predicted direction of that branch |
| fill_last_i | input | 1 | Close the trace after this micro-op |
| req_valid_i | input | 2 | Per-thread lookup request |
| req_pc_i | input | 32 | Per-thread start address, thread t in bits [16t+15:16t] |
| req_pred_i | input | 4 | Per-thread predicted directions, thread t in bits [2t+1:2t] |
| req_ack_o | output | 2 | Request of that thread looked up this cycle |
| miss_o | output | 1 | Lookup missed |
| miss_tid_o | output | 1 | Thread of the miss |
| out_valid_o | output | 1 | Beat valid |
| out_ready_i | input | 1 | Consumer accepts beat |
| out_tid_o | output | 1 | Thread of the beat |
| out_cnt_o | output | 2 | Micro-ops in the beat |
| out_uops_o | output | 48 | Beat micro-ops, slot 0 in the low bits |

## Verification
On every cycle, the assertions check the following: the line limits at the moment a line is written, alternation of the fetch slot and no idle slot while a thread is waiting, a stalled beat holding still, a miss never overlapping a beat, beat counts staying within 1 to 3, and no beat on the cycle after a flush. Which data a hit returns can only be shown by the bench's scenarios. The same holds for where a line closes, whether a wrong prediction or the other thread misses, and which way the pseudo-LRU evicts after a given history.

// File: rtl/tc_pkg.sv
package tc_pkg;
  localparam int TC_THREADS = 2;
  localparam int TC_MAX_BR  = 2;
  localparam int TC_BRC_W   = $clog2(TC_MAX_BR + 1);

  typedef logic                  tid_t;
  typedef logic [TC_MAX_BR-1:0]  dir_t;
  typedef logic [TC_BRC_W-1:0]   brcnt_t;

  // True when the first n stored directions equal the requested ones.
  function automatic logic dirs_agree(dir_t stored, dir_t want, brcnt_t n);
    logic ok;
    ok = 1'b1;
    for (int i = 0; i < TC_MAX_BR; i++) begin
      if (i < int'(n) && stored[i] != want[i]) ok = 1'b0;
    end
    return ok;
  endfunction
endpackage

// File: rtl/tc_line_builder.sv
module tc_line_builder
  import tc_pkg::*;
#(
  parameter int ADDR_W    = 16,
  parameter int UOP_W     = 16,
  parameter int LINE_UOPS = 6
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            flush_i,
  input  logic                            fill_valid_i,
  input  tid_t                            fill_tid_i,
  input  logic [ADDR_W-1:0]               fill_pc_i,
  input  logic [UOP_W-1:0]                fill_uop_i,
  input  logic                            fill_br_i,
  input  logic                            fill_taken_i,
  input  logic                            fill_last_i,
  output logic                            wr_en_o,
  output logic [ADDR_W-1:0]               wr_pc_o,
  output tid_t                            wr_tid_o,
  output dir_t                            wr_dirs_o,
  output brcnt_t                          wr_nbr_o,
  output logic [$clog2(LINE_UOPS+1)-1:0]  wr_len_o,
  output logic [LINE_UOPS-1:0][UOP_W-1:0] wr_uops_o
);
  localparam int POS_W = $clog2(LINE_UOPS + 1);

  logic [POS_W-1:0]               cnt_q, cnt_n, cnt_inc;
  brcnt_t                         nbr_q, nbr_n, nbr_inc;
  dir_t                           dirs_q, dirs_n, dirs_upd;
  logic [ADDR_W-1:0]              pc_q, pc_n;
  tid_t                           tid_q, tid_n;
  logic [LINE_UOPS-1:0][UOP_W-1:0] uops_q, uops_n;
  logic                           close;

  // Next-state: merge the incoming micro-op into the open line.
  always_comb begin
    uops_n   = uops_q;
    dirs_upd = dirs_q;
    pc_n     = pc_q;
    tid_n    = tid_q;
    cnt_inc  = cnt_q + POS_W'(1);
    nbr_inc  = nbr_q + brcnt_t'(fill_br_i);
    if (fill_valid_i) begin
      uops_n[int'(cnt_q)] = fill_uop_i;
      if (cnt_q == '0) begin
        pc_n  = fill_pc_i;
        tid_n = fill_tid_i;
      end
      if (fill_br_i && int'(nbr_q) < TC_MAX_BR) dirs_upd[int'(nbr_q)] = fill_taken_i;
    end
    close = fill_valid_i && ((cnt_inc == POS_W'(LINE_UOPS)) ||
                             (nbr_inc == brcnt_t'(TC_MAX_BR)) || fill_last_i);
    if (flush_i || close) begin
      cnt_n  = '0;
      nbr_n  = '0;
      dirs_n = '0;
    end else if (fill_valid_i) begin
      cnt_n  = cnt_inc;
      nbr_n  = nbr_inc;
      dirs_n = dirs_upd;
    end else begin
      cnt_n  = cnt_q;
      nbr_n  = nbr_q;
      dirs_n = dirs_q;
    end
  end

  assign wr_en_o   = close && !flush_i;
  assign wr_pc_o   = pc_n;
  assign wr_tid_o  = tid_n;
  assign wr_dirs_o = dirs_upd;
  assign wr_nbr_o  = nbr_inc;
  assign wr_len_o  = cnt_inc;
  assign wr_uops_o = uops_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      nbr_q  <= '0;
      dirs_q <= '0;
    end else begin
      cnt_q  <= cnt_n;
      nbr_q  <= nbr_n;
      dirs_q <= dirs_n;
    end
  end

  always_ff @(posedge clk) begin
    if (fill_valid_i) begin
      uops_q <= uops_n;
      pc_q   <= pc_n;
      tid_q  <= tid_n;
    end
  end

  // R2 R3: a written line never exceeds its micro-op or branch budget
  a_r3_line_limits: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en_o |-> (int'(wr_len_o) <= LINE_UOPS) && (int'(wr_nbr_o) <= TC_MAX_BR));

  // R2: an open line never holds a full budget across a clock edge
  a_r2_open_below_full: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_valid_i && !wr_en_o && !flush_i) |=> (int'(cnt_q) < LINE_UOPS));
endmodule

// File: rtl/tc_thread_arb.sv
module tc_thread_arb
  import tc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] want_i,
  input  logic       hold_i,
  output logic       grant_valid_o,
  output tid_t       grant_o
);
  tid_t last_q, last_n;

  always_comb begin
    grant_o       = last_q;
    grant_valid_o = 1'b0;
    if (hold_i) begin
      grant_o       = last_q;
      grant_valid_o = want_i[last_q];
    end else if (want_i[~last_q]) begin
      grant_o       = ~last_q;
      grant_valid_o = 1'b1;
    end else if (want_i[last_q]) begin
      grant_o       = last_q;
      grant_valid_o = 1'b1;
    end
    last_n = grant_valid_o ? grant_o : last_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) last_q <= 1'b1;
    else        last_q <= last_n;
  end

  // R8: with both threads waiting and no stall, the slot changes hands
  a_r8_alternate: assert property (@(posedge clk) disable iff (!rst_n)
    (&want_i && !hold_i && $past(grant_valid_o)) |-> (grant_o != $past(grant_o)));

  // R8: a waiting thread is never left with an idle slot
  a_r8_no_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (|want_i && !hold_i) |-> (grant_valid_o && want_i[grant_o]));
endmodule

// File: rtl/tc_way_match.sv
module tc_way_match
  import tc_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int WAYS   = 8
) (
  input  logic [WAYS-1:0]              vld_i,
  input  logic [WAYS-1:0][ADDR_W-1:0]  pc_i,
  input  logic [WAYS-1:0]              tid_i,
  input  logic [WAYS-1:0][TC_BRC_W-1:0] nbr_i,
  input  logic [WAYS-1:0][TC_MAX_BR-1:0] dir_i,
  input  logic [ADDR_W-1:0]            q_pc_i,
  input  tid_t                         q_tid_i,
  input  dir_t                         q_dir_i,
  input  brcnt_t                       q_nbr_i,
  input  logic                         exact_i,
  output logic                         hit_o,
  output logic [$clog2(WAYS)-1:0]      way_o
);
  localparam int WAY_W = $clog2(WAYS);

  logic [WAYS-1:0] match;

  for (genvar w = 0; w < WAYS; w++) begin : g_cmp
    logic dir_ok;
    assign dir_ok = exact_i ? ((nbr_i[w] == q_nbr_i) && (dir_i[w] == q_dir_i))
                            : dirs_agree(dir_i[w], q_dir_i, nbr_i[w]);
    assign match[w] = vld_i[w] && (pc_i[w] == q_pc_i) && (tid_i[w] == q_tid_i) && dir_ok;
  end

  always_comb begin
    hit_o = 1'b0;
    way_o = '0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (match[w]) begin
        hit_o = 1'b1;
        way_o = WAY_W'(w);
      end
    end
  end
endmodule

// File: rtl/tc_plru.sv
module tc_plru #(
  parameter int WAYS = 8
) (
  input  logic [WAYS-1:1]         tree_i,
  input  logic [$clog2(WAYS)-1:0] use_i,
  output logic [$clog2(WAYS)-1:0] victim_o,
  output logic [WAYS-1:1]         tree_o
);
  localparam int LVL = $clog2(WAYS);

  // Follow the node bits down to the least recently used leaf.
  always_comb begin
    int n;
    int v;
    n = 1;
    v = 0;
    for (int l = 0; l < LVL; l++) begin
      v = v * 2 + int'(tree_i[n]);
      n = n * 2 + int'(tree_i[n]);
    end
    victim_o = LVL'(v);
  end

  // Point every node on the used path away from the used way.
  always_comb begin
    int n;
    logic d;
    tree_o = tree_i;
    n = 1;
    for (int l = 0; l < LVL; l++) begin
      d = use_i[LVL-1-l];
      tree_o[n] = ~d;
      n = n * 2 + int'(d);
    end
  end
endmodule

// File: rtl/tc_trace_cache.sv
module tc_trace_cache
  import tc_pkg::*;
#(
  parameter int SETS      = 8,
  parameter int WAYS      = 8,
  parameter int LINE_UOPS = 6,
  parameter int DELIVER   = 3,
  parameter int ADDR_W    = 16,
  parameter int UOP_W     = 16
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        flush_i,
  input  logic                        fill_valid_i,
  input  logic                        fill_tid_i,
  input  logic [ADDR_W-1:0]           fill_pc_i,
  input  logic [UOP_W-1:0]            fill_uop_i,
  input  logic                        fill_br_i,
  input  logic                        fill_taken_i,
  input  logic                        fill_last_i,
  input  logic [1:0]                  req_valid_i,
  input  logic [2*ADDR_W-1:0]         req_pc_i,
  input  logic [2*TC_MAX_BR-1:0]      req_pred_i,
  output logic [1:0]                  req_ack_o,
  output logic                        miss_o,
  output logic                        miss_tid_o,
  output logic                        out_valid_o,
  input  logic                        out_ready_i,
  output logic                        out_tid_o,
  output logic [$clog2(DELIVER+1)-1:0] out_cnt_o,
  output logic [DELIVER*UOP_W-1:0]    out_uops_o
);
  localparam int IDX_W = $clog2(SETS);
  localparam int WAY_W = $clog2(WAYS);
  localparam int POS_W = $clog2(LINE_UOPS + 1);
  localparam int CNT_W = $clog2(DELIVER + 1);

  // Reset: asserted at once, released through two flops.
  logic rs_meta_q, srst_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) {srst_n, rs_meta_q} <= 2'b00;
    else        {srst_n, rs_meta_q} <= {rs_meta_q, 1'b1};
  end

  // Line storage.
  logic [WAYS-1:0]                  vld_q [SETS];
  logic [WAYS-1:0]                  vld_n [SETS];
  logic [WAYS-1:1]                  plru_q [SETS];
  logic [WAYS-1:1]                  plru_n [SETS];
  logic [WAYS-1:0][ADDR_W-1:0]      tpc_q  [SETS];
  logic [WAYS-1:0]                  ttid_q [SETS];
  logic [WAYS-1:0][TC_BRC_W-1:0]    tnbr_q [SETS];
  logic [WAYS-1:0][TC_MAX_BR-1:0]   tdir_q [SETS];
  logic [WAYS-1:0][POS_W-1:0]       tlen_q [SETS];
  logic [LINE_UOPS-1:0][UOP_W-1:0]  data_q [SETS][WAYS];

  // Builder.
  logic                            wr_en;
  logic [ADDR_W-1:0]               wr_pc;
  tid_t                            wr_tid;
  dir_t                            wr_dirs;
  brcnt_t                          wr_nbr;
  logic [POS_W-1:0]                wr_len;
  logic [LINE_UOPS-1:0][UOP_W-1:0] wr_uops;

  tc_line_builder #(.ADDR_W(ADDR_W), .UOP_W(UOP_W), .LINE_UOPS(LINE_UOPS)) u_build (
    .clk, .rst_n(srst_n), .flush_i,
    .fill_valid_i, .fill_tid_i, .fill_pc_i, .fill_uop_i,
    .fill_br_i, .fill_taken_i, .fill_last_i,
    .wr_en_o(wr_en), .wr_pc_o(wr_pc), .wr_tid_o(wr_tid), .wr_dirs_o(wr_dirs),
    .wr_nbr_o(wr_nbr), .wr_len_o(wr_len), .wr_uops_o(wr_uops)
  );

  // Per-thread stream state.
  logic [1:0]                  act_q, act_n;
  logic [1:0][IDX_W-1:0]       sset_q, sset_n;
  logic [1:0][WAY_W-1:0]       sway_q, sway_n;
  logic [1:0][POS_W-1:0]       spos_q, spos_n;
  logic                        stall_q, stall_n;

  // Slot arbitration.
  logic grant_v;
  tid_t g;
  tc_thread_arb u_arb (
    .clk, .rst_n(srst_n), .want_i(act_q | req_valid_i), .hold_i(stall_q),
    .grant_valid_o(grant_v), .grant_o(g)
  );

  // Lookup.
  logic [ADDR_W-1:0] q_pc;
  dir_t              q_pred;
  logic [IDX_W-1:0]  q_set;
  logic              look, f_hit;
  logic [WAY_W-1:0]  f_way;

  assign q_pc   = req_pc_i[int'(g)*ADDR_W +: ADDR_W];
  assign q_pred = req_pred_i[int'(g)*TC_MAX_BR +: TC_MAX_BR];
  assign q_set  = q_pc[IDX_W-1:0];
  assign look   = grant_v && !act_q[g] && req_valid_i[g];

  tc_way_match #(.ADDR_W(ADDR_W), .WAYS(WAYS)) u_fmatch (
    .vld_i(vld_q[q_set]), .pc_i(tpc_q[q_set]), .tid_i(ttid_q[q_set]),
    .nbr_i(tnbr_q[q_set]), .dir_i(tdir_q[q_set]),
    .q_pc_i(q_pc), .q_tid_i(g), .q_dir_i(q_pred), .q_nbr_i('0), .exact_i(1'b0),
    .hit_o(f_hit), .way_o(f_way)
  );

  assign req_ack_o  = look ? (2'b01 << g) : 2'b00;
  assign miss_o     = look && !f_hit;
  assign miss_tid_o = g;

  // Delivery.
  logic              dv, accept, s_done;
  logic [IDX_W-1:0]  d_set;
  logic [WAY_W-1:0]  d_way;
  logic [POS_W-1:0]  d_pos, d_len, remain;
  logic [CNT_W-1:0]  d_cnt;

  assign dv     = grant_v && act_q[g];
  assign d_set  = sset_q[g];
  assign d_way  = sway_q[g];
  assign d_pos  = spos_q[g];
  assign d_len  = tlen_q[d_set][d_way];
  assign remain = d_len - d_pos;
  assign d_cnt  = (int'(remain) > DELIVER) ? CNT_W'(DELIVER) : CNT_W'(remain);
  assign accept = dv && out_ready_i;
  assign s_done = (int'(d_pos) + int'(d_cnt)) >= int'(d_len);

  always_comb begin
    for (int k = 0; k < DELIVER; k++) begin
      out_uops_o[k*UOP_W +: UOP_W] = '0;
      if (k < int'(d_cnt) && int'(d_pos) + k < LINE_UOPS)
        out_uops_o[k*UOP_W +: UOP_W] = data_q[d_set][d_way][int'(d_pos) + k];
    end
  end

  assign out_valid_o = dv;
  assign out_tid_o   = g;
  assign out_cnt_o   = d_cnt;

  // Fill placement and replacement.
  logic [IDX_W-1:0] w_set;
  logic             dup_hit, inv_found;
  logic [WAY_W-1:0] dup_way, inv_way, vic_way, w_way, vic_unused;
  logic [WAYS-1:1]  tree_fetch, tree_fill_in, tree_fill;

  assign w_set = wr_pc[IDX_W-1:0];

  tc_way_match #(.ADDR_W(ADDR_W), .WAYS(WAYS)) u_dmatch (
    .vld_i(vld_q[w_set]), .pc_i(tpc_q[w_set]), .tid_i(ttid_q[w_set]),
    .nbr_i(tnbr_q[w_set]), .dir_i(tdir_q[w_set]),
    .q_pc_i(wr_pc), .q_tid_i(wr_tid), .q_dir_i(wr_dirs), .q_nbr_i(wr_nbr), .exact_i(1'b1),
    .hit_o(dup_hit), .way_o(dup_way)
  );

  tc_plru #(.WAYS(WAYS)) u_plru_fetch (
    .tree_i(plru_q[q_set]), .use_i(f_way), .victim_o(vic_unused), .tree_o(tree_fetch)
  );

  assign tree_fill_in = (look && f_hit && (w_set == q_set)) ? tree_fetch : plru_q[w_set];

  tc_plru #(.WAYS(WAYS)) u_plru_fill (
    .tree_i(tree_fill_in), .use_i(w_way), .victim_o(vic_way), .tree_o(tree_fill)
  );

  always_comb begin
    inv_found = 1'b0;
    inv_way   = '0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (!vld_q[w_set][w]) begin
        inv_found = 1'b1;
        inv_way   = WAY_W'(w);
      end
    end
  end

  assign w_way = dup_hit ? dup_way : (inv_found ? inv_way : vic_way);

  // Next-state for valid bits, LRU trees and streams.
  always_comb begin
    vld_n  = vld_q;
    plru_n = plru_q;
    if (look && f_hit) plru_n[q_set] = tree_fetch;
    if (wr_en) begin
      vld_n[w_set][w_way] = 1'b1;
      plru_n[w_set]       = tree_fill;
    end
    if (flush_i) begin
      for (int s = 0; s < SETS; s++) begin
        vld_n[s]  = '0;
        plru_n[s] = '0;
      end
    end
  end

  always_comb begin
    act_n   = act_q;
    sset_n  = sset_q;
    sway_n  = sway_q;
    spos_n  = spos_q;
    stall_n = dv && !out_ready_i && !flush_i;
    for (int t = 0; t < TC_THREADS; t++) begin
      if (flush_i) begin
        act_n[t] = 1'b0;
      end else if (look && f_hit && int'(g) == t) begin
        act_n[t]  = 1'b1;
        sset_n[t] = q_set;
        sway_n[t] = f_way;
        spos_n[t] = '0;
      end else if (accept && int'(g) == t) begin
        if (s_done) act_n[t] = 1'b0;
        else        spos_n[t] = d_pos + POS_W'(d_cnt);
      end
    end
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      for (int s = 0; s < SETS; s++) begin
        vld_q[s]  <= '0;
        plru_q[s] <= '0;
      end
      act_q   <= '0;
      sset_q  <= '0;
      sway_q  <= '0;
      spos_q  <= '0;
      stall_q <= 1'b0;
    end else begin
      vld_q   <= vld_n;
      plru_q  <= plru_n;
      act_q   <= act_n;
      sset_q  <= sset_n;
      sway_q  <= sway_n;
      spos_q  <= spos_n;
      stall_q <= stall_n;
    end
  end

  // Tag and data arrays: written only, never reset.
  always_ff @(posedge clk) begin
    if (wr_en && !flush_i) begin
      tpc_q[w_set][w_way]  <= wr_pc;
      ttid_q[w_set][w_way] <= wr_tid;
      tnbr_q[w_set][w_way] <= wr_nbr;
      tdir_q[w_set][w_way] <= wr_dirs;
      tlen_q[w_set][w_way] <= wr_len;
      data_q[w_set][w_way] <= wr_uops;
    end
  end

  // R6: a refused beat is presented again unchanged
  a_r6_hold_stable: assert property (@(posedge clk) disable iff (!srst_n)
    (out_valid_o && !out_ready_i && !flush_i) |=>
      (out_valid_o && $stable(out_tid_o) && $stable(out_cnt_o) && $stable(out_uops_o)));

  // R9: nothing is delivered on the cycle after a flush
  a_r9_flush_clears: assert property (@(posedge clk) disable iff (!srst_n)
    flush_i |=> !out_valid_o);

  // R7: a miss is tied to an acknowledge and never shares the slot with a beat
  a_r7_miss_alone: assert property (@(posedge clk) disable iff (!srst_n)
    miss_o |-> (!out_valid_o && (req_ack_o != 2'b00)));

  // R5: every beat carries between one and DELIVER micro-ops
  a_r5_beat_size: assert property (@(posedge clk) disable iff (!srst_n)
    out_valid_o |-> ((out_cnt_o != '0) && (int'(out_cnt_o) <= DELIVER)));

  // R8: at most one thread is acknowledged per cycle
  a_r8_one_ack: assert property (@(posedge clk) disable iff (!srst_n)
    $onehot0(req_ack_o));
endmodule

// File: tb/tc_trace_cache_test.sv
module tc_trace_cache_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        flush_i;
  logic        fill_valid_i, fill_tid_i, fill_br_i, fill_taken_i, fill_last_i;
  logic [15:0] fill_pc_i, fill_uop_i;
  logic [1:0]  req_valid_i;
  logic [31:0] req_pc_i;
  logic [3:0]  req_pred_i;
  logic [1:0]  req_ack_o;
  logic        miss_o, miss_tid_o, out_valid_o, out_ready_i, out_tid_o;
  logic [1:0]  out_cnt_o;
  logic [47:0] out_uops_o;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  tc_trace_cache uut (
    .clk, .rst_n, .flush_i,
    .fill_valid_i, .fill_tid_i, .fill_pc_i, .fill_uop_i,
    .fill_br_i, .fill_taken_i, .fill_last_i,
    .req_valid_i, .req_pc_i, .req_pred_i, .req_ack_o,
    .miss_o, .miss_tid_o,
    .out_valid_o, .out_ready_i, .out_tid_o, .out_cnt_o, .out_uops_o
  );

  always #4 clk = ~clk;

  task automatic chk(input bit ok, input string rq, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  task automatic summary();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    #(8 * 150000);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
    summary();
  end

  task automatic do_flush();
    @(negedge clk); flush_i = 1'b1;
    @(negedge clk); flush_i = 1'b0;
  endtask

  // Feed n micro-ops base+i, pc+i; branch/taken flags per index.
  task automatic fill_line(input bit tid, input logic [15:0] pc, input int n,
                           input logic [15:0] base, input logic [7:0] brv,
                           input logic [7:0] tkv, input bit use_last);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      fill_valid_i = 1'b1;
      fill_tid_i   = tid;
      fill_pc_i    = pc + 16'(i);
      fill_uop_i   = base + 16'(i);
      fill_br_i    = brv[i];
      fill_taken_i = tkv[i];
      fill_last_i  = use_last && (i == n - 1);
    end
    @(negedge clk);
    fill_valid_i = 1'b0;
    fill_last_i  = 1'b0;
  endtask

  task automatic fetch(input bit tid, input logic [15:0] pc, input logic [1:0] pred,
                       input bit exp_hit, input int len, input logic [15:0] base,
                       input string rq);
    int pos;
    int c;
    @(negedge clk);
    req_valid_i[tid] = 1'b1;
    req_pc_i[int'(tid)*16 +: 16] = pc;
    req_pred_i[int'(tid)*2 +: 2] = pred;
    out_ready_i = 1'b1;
    #1;
    chk(req_ack_o[tid] == 1'b1, {rq, " ack"}, req_ack_o, 1 << tid);
    chk(miss_o == !exp_hit, {rq, " R7 miss flag"}, miss_o, !exp_hit);
    if (!exp_hit) chk(miss_tid_o == tid, {rq, " R7 miss tid"}, miss_tid_o, tid);
    @(negedge clk);
    req_valid_i[tid] = 1'b0;
    pos = 0;
    if (exp_hit) begin
      while (pos < len) begin
        c = (len - pos > 3) ? 3 : len - pos;
        #1;
        chk(out_valid_o && out_tid_o == tid, {rq, " R5 beat valid/tid"},
            {out_valid_o, out_tid_o}, {1'b1, tid});
        chk(int'(out_cnt_o) == c, {rq, " R5 beat count"}, out_cnt_o, c);
        for (int k = 0; k < c; k++)
          chk(out_uops_o[k*16 +: 16] == base + 16'(pos + k), {rq, " R5 uop order"},
              out_uops_o[k*16 +: 16], base + 16'(pos + k));
        pos += c;
        @(negedge clk);
      end
    end
    #1;
    chk(out_valid_o == 1'b0, {rq, " stream ended"}, out_valid_o, 0);
  endtask

  task automatic t_reset();
    chk(out_valid_o == 1'b0 && req_ack_o == 2'b00 && miss_o == 1'b0,
        "R1 idle after reset", {out_valid_o, req_ack_o, miss_o}, 0);
    fetch(1'b0, 16'h0000, 2'b00, 1'b0, 0, 16'h0, "R1 cold lookup");
  endtask

  task automatic t_full_line();
    fill_line(1'b0, 16'h0101, 6, 16'h0100, 8'h00, 8'h00, 1'b0);
    fetch(1'b0, 16'h0101, 2'b00, 1'b1, 6, 16'h0100, "R2 six-op close");
    fill_line(1'b0, 16'h0301, 7, 16'h0300, 8'h00, 8'h00, 1'b1);
    fetch(1'b0, 16'h0301, 2'b00, 1'b1, 6, 16'h0300, "R2 split head");
    fetch(1'b0, 16'h0307, 2'b00, 1'b1, 1, 16'h0306, "R2 split tail");
  endtask

  task automatic t_branches();
    // branch 0 at op 1 taken, branch 1 at op 3 not taken -> pred bit0=1, bit1=0
    fill_line(1'b0, 16'h0202, 4, 16'h0200, 8'b0000_1010, 8'b0000_0010, 1'b0);
    fetch(1'b0, 16'h0202, 2'b01, 1'b1, 4, 16'h0200, "R3 second-branch close, R4 match");
    fetch(1'b0, 16'h0202, 2'b11, 1'b0, 0, 16'h0, "R4 wrong second direction");
    fetch(1'b0, 16'h0202, 2'b00, 1'b0, 0, 16'h0, "R4 wrong first direction");
    fill_line(1'b0, 16'h0405, 2, 16'h0400, 8'h00, 8'h00, 1'b1);
    fetch(1'b0, 16'h0405, 2'b10, 1'b1, 2, 16'h0400, "R3 last-flag close");
  endtask

  task automatic t_threads();
    fetch(1'b1, 16'h0101, 2'b00, 1'b0, 0, 16'h0, "R11 other thread misses");
    fill_line(1'b1, 16'h0101, 6, 16'h0900, 8'h00, 8'h00, 1'b0);
    fetch(1'b1, 16'h0101, 2'b00, 1'b1, 6, 16'h0900, "R11 thread 1 own line");
    fetch(1'b0, 16'h0101, 2'b00, 1'b1, 6, 16'h0100, "R11 thread 0 line kept");
  endtask

  task automatic t_stall();
    logic [47:0] held;
    @(negedge clk);
    req_valid_i[0] = 1'b1;
    req_pc_i[15:0] = 16'h0101;
    req_pred_i[1:0] = 2'b00;
    out_ready_i = 1'b0;
    @(negedge clk);
    req_valid_i[0] = 1'b0;
    #1;
    held = out_uops_o;
    chk(out_valid_o && out_cnt_o == 2'd3 && held[15:0] == 16'h0100,
        "R6 first beat shown", held[15:0], 16'h0100);
    @(negedge clk);
    #1;
    chk(out_valid_o && out_uops_o == held && out_cnt_o == 2'd3,
        "R6 beat held while refused", out_uops_o[15:0], held[15:0]);
    @(negedge clk);
    out_ready_i = 1'b1;
    #1;
    chk(out_valid_o && out_uops_o[15:0] == 16'h0100, "R6 beat after release",
        out_uops_o[15:0], 16'h0100);
    @(negedge clk);
    #1;
    chk(out_valid_o && out_uops_o[15:0] == 16'h0103, "R6 second beat", out_uops_o[15:0],
        16'h0103);
    @(negedge clk);
    #1;
    chk(!out_valid_o, "R6 stream done", out_valid_o, 0);
  endtask

  task automatic t_alternate();
    bit first;
    bit other;
    bit t;
    @(negedge clk);
    req_valid_i = 2'b11;
    req_pc_i = {16'h0101, 16'h0101};
    req_pred_i = 4'b0000;
    out_ready_i = 1'b1;
    #1;
    chk(req_ack_o == 2'b01 || req_ack_o == 2'b10, "R8 one ack", req_ack_o, 1);
    first = req_ack_o[1];
    other = ~first;
    @(negedge clk);
    req_valid_i[first] = 1'b0;
    #1;
    chk(req_ack_o[other] == 1'b1, "R8 other thread next slot", req_ack_o, 1 << other);
    @(negedge clk);
    req_valid_i = 2'b00;
    for (int b = 0; b < 4; b++) begin
      t = (b % 2 == 0) ? first : other;
      #1;
      chk(out_valid_o && out_tid_o == t, "R8 beats alternate", out_tid_o, t);
      chk(out_uops_o[15:0] == ((t ? 16'h0900 : 16'h0100) + 16'(3 * (b / 2))),
          "R8 beat data per thread", out_uops_o[15:0],
          (t ? 16'h0900 : 16'h0100) + 16'(3 * (b / 2)));
      @(negedge clk);
    end
    #1;
    chk(!out_valid_o, "R8 both streams done", out_valid_o, 0);
  endtask

  task automatic t_flush();
    do_flush();
    fetch(1'b0, 16'h0101, 2'b00, 1'b0, 0, 16'h0, "R9 flushed line misses");
    fetch(1'b1, 16'h0101, 2'b00, 1'b0, 0, 16'h0, "R9 flushed thread 1 misses");
  endtask

  task automatic t_replace();
    for (int i = 0; i < 8; i++)
      fill_line(1'b0, 16'(8 * i), 2, 16'h1000 + 16'(16 * i), 8'h00, 8'h00, 1'b1);
    fetch(1'b0, 16'h0000, 2'b00, 1'b1, 2, 16'h1000, "R10 way 0 hit");
    // After ways 0..7 filled in order and way 0 touched, tree victim is way 4 (pc 32).
    fill_line(1'b0, 16'h0040, 2, 16'h2000, 8'h00, 8'h00, 1'b1);
    fetch(1'b0, 16'h0020, 2'b00, 1'b0, 0, 16'h0, "R10 LRU victim evicted");
    fetch(1'b0, 16'h0040, 2'b00, 1'b1, 2, 16'h2000, "R10 new line present");
    fill_line(1'b0, 16'h0008, 2, 16'h3000, 8'h00, 8'h00, 1'b1);
    fetch(1'b0, 16'h0008, 2'b00, 1'b1, 2, 16'h3000, "R10 rewrite same tag");
    for (int i = 0; i < 8; i++) begin
      if (i != 1 && i != 4)
        fetch(1'b0, 16'(8 * i), 2'b00, 1'b1, 2, 16'h1000 + 16'(16 * i), "R10 others kept");
    end
    fetch(1'b0, 16'h0040, 2'b00, 1'b1, 2, 16'h2000, "R10 rewrite evicted nothing");
  endtask

  initial begin
    rst_n = 1'b0;
    flush_i = 1'b0;
    fill_valid_i = 1'b0; fill_tid_i = 1'b0; fill_br_i = 1'b0;
    fill_taken_i = 1'b0; fill_last_i = 1'b0;
    fill_pc_i = '0; fill_uop_i = '0;
    req_valid_i = '0; req_pc_i = '0; req_pred_i = '0;
    out_ready_i = 1'b1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    #1;
    t_reset();
    t_full_line();
    t_branches();
    t_threads();
    t_stall();
    t_alternate();
    t_flush();
    t_replace();
    repeat (2) @(negedge clk);
    summary();
  end
endmodule